// File: doc/BRIEF.md
# Single-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer that runs on one clock and keeps its words in an inferred memory array that maps onto block RAM. A producer pushes words with a write strobe; a consumer pulls them with a read strobe. Four registered status flags report the fill level. Two of them, full and empty, are fixed. The other two, near-full and near-empty, have thresholds set by 13-bit parameters. Two sticky error outputs record any write refused because the buffer was full, and any read request that could not be served. Both stay set until reset.

Two options select how read data is presented. In request mode, data is fetched on a read strobe. It arrives one cycle later, or two cycles later when the extra output register is enabled. The `dout_valid` output marks the cycle in which it arrives. In fall-through mode, the oldest word already sits on the output with `dout_valid` high, and the read strobe acknowledges it and removes it. Fall-through mode relies on the output register, so that combination is required. The legal configurations are: request mode without the register, request mode with the register, and fall-through mode with the register. An illegal setting stops elaboration.

Top module: `sfifo_prog`

## Requirements
- R1: An occupancy count runs from 0 to DEPTH. A write is accepted only while `full` is low. `full` is high when the count equals DEPTH, and `empty` is high when the count is 0. All flags reflect the count after the most recent clock edge.
- R2: `almost_full` is high exactly when DEPTH minus the count is at most ALMOST_FULL_GAP.
- R3: `almost_empty` is high exactly when the count is at most ALMOST_EMPTY_GAP.
- R4: In request mode without the output register, a read strobe seen while not empty removes the oldest word. That word appears on `dout` with `dout_valid` high one clock edge later, and `dout_valid` is high only in such cycles.
- R5: In request mode with the output register, the same holds with two clock edges between the read strobe and the valid data.
- R6: In fall-through mode, a word written into an empty buffer is on `dout` with `dout_valid` high no later than the second clock edge after the write. No read strobe is needed. The word holds there until a read strobe, and a read strobe while `dout_valid` is high removes it.
- R7: Words leave in the order they were accepted, with their values unchanged.
- R8: A write while full and a read that cannot be served change neither the count nor the stored words. The first sets `overflow` and the second sets `underflow`, and both stay high until reset. A read cannot be served when the buffer is empty in request mode, or when `dout_valid` is low in fall-through mode.
- R9: A write and a served read in the same cycle, while not full, leave the count unchanged.
- R10: Synchronous active-high `rst` clears the count and both error outputs, and drives `full` low, `almost_full` low, `empty` high, `almost_empty` high and `dout_valid` low.
- R11: Elaboration stops on any of these settings: fall-through mode without the output register; a data width other than 4, 9, 18, 36 or 72; a DEPTH that is not a power of two of at least 2; or a threshold not below DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| din | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe (request mode) or acknowledge (fall-through mode) |
| dout | output | DATA_W | Read data |
| dout_valid | output | 1 | `dout` carries a word |
| full | output | 1 | Count equals DEPTH |
| empty | output | 1 | Count is zero |
| almost_full | output | 1 | Free space at or below its threshold |
| almost_empty | output | 1 | Count at or below its threshold |
| overflow | output | 1 | Sticky: write refused while full |
| underflow | output | 1 | Sticky: read request not served |

## Verification
The assertions take for granted that `rst` is held for at least one edge before the first transfer. They also assume that `wr_en` and `rd_en` are known 0/1 values in every cycle outside reset. Beyond that, they accept any strobe pattern, including writes into a full buffer and reads with nothing to deliver. The stimulus holds reset at start and again in mid-run, and drives the strobes only at the falling edge. It deliberately pushes past full and pulls past empty, so that the refusal paths and sticky flags are exercised within these assumptions.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  typedef struct packed {
    logic full;
    logic empty;
    logic afull;
    logic aempty;
  } sfifo_flags_t;

  function automatic bit width_ok(int w);
    return (w == 4) || (w == 9) || (w == 18) || (w == 36) || (w == 72);
  endfunction

endpackage

// File: rtl/sfifo_ram.sv
module sfifo_ram #(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  // plain synchronous write and registered read: maps to block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int          DEPTH     = 16,
  parameter int          ADDR_W    = 4,
  parameter logic [12:0] AF_GAP    = 13'h3,
  parameter logic [12:0] AE_GAP    = 13'h2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic              take,
  input  logic              advance,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              mem_avail,
  output sfifo_flags_t      flags,
  output logic              ovf,
  output logic              udf
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] AF_LIM  = CNT_W'(AF_GAP);
  localparam logic [CNT_W-1:0] AE_LIM  = CNT_W'(AE_GAP);

  logic [CNT_W-1:0] wr_ptr, rd_ptr, cnt, cnt_nxt;

  assign wr_fire   = wr_req && !flags.full;
  assign wr_addr   = wr_ptr[ADDR_W-1:0];
  assign rd_addr   = rd_ptr[ADDR_W-1:0];
  assign mem_avail = (wr_ptr != rd_ptr);

  always_comb cnt_nxt = cnt + CNT_W'(wr_fire) - CNT_W'(take);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr       <= '0;
      rd_ptr       <= '0;
      cnt          <= '0;
      flags.full   <= 1'b0;
      flags.empty  <= 1'b1;
      flags.afull  <= 1'b0;
      flags.aempty <= 1'b1;
      ovf          <= 1'b0;
      udf          <= 1'b0;
    end else begin
      if (wr_fire) wr_ptr <= wr_ptr + 1'b1;
      if (advance) rd_ptr <= rd_ptr + 1'b1;
      cnt          <= cnt_nxt;
      flags.full   <= (cnt_nxt == DEPTH_C);
      flags.empty  <= (cnt_nxt == '0);
      flags.afull  <= ((DEPTH_C - cnt_nxt) <= AF_LIM);
      flags.aempty <= (cnt_nxt <= AE_LIM);
      if (wr_req && flags.full) ovf <= 1'b1;
      if (rd_req && !take)      udf <= 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= DEPTH_C); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (flags.full && !take) |=> flags.full); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (flags.empty && !wr_req) |=> flags.empty); // R8
  AST_RW_BALANCE: assert property (@(posedge clk) disable iff (rst)
    (wr_req && take && !flags.full) |=> $stable(cnt)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R8
endmodule

// File: rtl/sfifo_out.sv
module sfifo_out #(
  parameter int DATA_W  = 4,
  parameter bit FWFT    = 1'b0,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              mem_avail,
  input  logic [DATA_W-1:0] mem_q,
  output logic              mem_rd,
  output logic              take,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid
);
  if (FWFT) begin : g_fwft
    // s1: word held in the memory read register, s2: word on the output
    logic              s1, s2, s2_load;
    logic [DATA_W-1:0] dout_r;

    assign take    = rd_req && s2;
    assign s2_load = s1 && (!s2 || take);
    assign mem_rd  = mem_avail && (!s1 || s2_load);

    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= mem_rd || (s1 && !s2_load);
        s2 <= s2_load || (s2 && !take);
      end
      if (s2_load) dout_r <= mem_q;
    end

    assign dout       = dout_r;
    assign dout_valid = s2;

    AST_FWFT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (s2 && !rd_req) |=> (s2 && $stable(dout_r))); // R6
  end else begin : g_req
    localparam int LAT = OUT_REG ? 2 : 1;
    logic v1;

    assign mem_rd = rd_req && mem_avail;
    assign take   = mem_rd;

    always_ff @(posedge clk) begin
      if (rst) v1 <= 1'b0;
      else     v1 <= mem_rd;
    end

    if (OUT_REG) begin : g_reg
      logic              v2;
      logic [DATA_W-1:0] dout_r;
      always_ff @(posedge clk) begin
        if (rst) v2 <= 1'b0;
        else     v2 <= v1;
        if (v1) dout_r <= mem_q;
      end
      assign dout       = dout_r;
      assign dout_valid = v2;
    end else begin : g_direct
      assign dout       = mem_q;
      assign dout_valid = v1;
    end

    AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (rst)
      dout_valid |-> $past(rd_req, LAT)); // R4 R5
  end
endmodule

// File: rtl/sfifo_prog.sv
module sfifo_prog
  import sfifo_pkg::*;
#(
  parameter int          DATA_W           = 4,
  parameter int          DEPTH            = 16,
  parameter logic [12:0] ALMOST_FULL_GAP  = 13'h3,
  parameter logic [12:0] ALMOST_EMPTY_GAP = 13'h2,
  parameter bit          FWFT             = 1'b0,
  parameter bit          OUT_REG          = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_en,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid,
  output logic              full,
  output logic              empty,
  output logic              almost_full,
  output logic              almost_empty,
  output logic              overflow,
  output logic              underflow
);
  localparam int ADDR_W = $clog2(DEPTH);

  initial begin
    AST_MODE_LEGAL: assert (!(FWFT && !OUT_REG))
      else $fatal(1, "fall-through mode needs the output register"); // R11
    AST_WIDTH_LEGAL: assert (width_ok(DATA_W))
      else $fatal(1, "unsupported data width"); // R11
    AST_DEPTH_LEGAL: assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
      else $fatal(1, "depth must be a power of two"); // R11
    AST_GAP_LEGAL: assert (int'(ALMOST_FULL_GAP) < DEPTH && int'(ALMOST_EMPTY_GAP) < DEPTH)
      else $fatal(1, "threshold must be below depth"); // R11
  end

  logic              wr_fire, mem_avail, mem_rd, take;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] mem_q;
  sfifo_flags_t      flags;

  sfifo_ctrl #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W),
    .AF_GAP(ALMOST_FULL_GAP), .AE_GAP(ALMOST_EMPTY_GAP)
  ) ctrl_i (
    .clk(clk), .rst(rst), .wr_req(wr_en), .rd_req(rd_en),
    .take(take), .advance(mem_rd), .wr_fire(wr_fire),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .mem_avail(mem_avail),
    .flags(flags), .ovf(overflow), .udf(underflow)
  );

  sfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
    .clk(clk), .wr_en(wr_fire), .wr_addr(wr_addr), .wr_data(din),
    .rd_en(mem_rd), .rd_addr(rd_addr), .rd_data(mem_q)
  );

  sfifo_out #(.DATA_W(DATA_W), .FWFT(FWFT), .OUT_REG(OUT_REG)) out_i (
    .clk(clk), .rst(rst), .rd_req(rd_en), .mem_avail(mem_avail),
    .mem_q(mem_q), .mem_rd(mem_rd), .take(take),
    .dout(dout), .dout_valid(dout_valid)
  );

  assign full         = flags.full;
  assign empty        = flags.empty;
  assign almost_full  = flags.afull;
  assign almost_empty = flags.aempty;

  AST_TAKE_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    take |-> !flags.empty); // R1
endmodule

// File: tb/sfifo_prog_tb_top.sv
`timescale 1ns/1ps

module sfifo_prog_tb_cfg #(
  parameter string NAME    = "cfg",
  parameter int    DATA_W  = 4,
  parameter bit    FWFT    = 1'b0,
  parameter bit    OUT_REG = 1'b1,
  parameter int    DEPTH   = 16,
  parameter int    AF      = 3,
  parameter int    AE      = 2
) (
  input  logic clk,
  output logic done,
  output int   checks,
  output int   errors
);
  logic              rst, wr_en, rd_en;
  logic [DATA_W-1:0] din, dout;
  logic              dout_valid, full, empty, almost_full, almost_empty, overflow, underflow;

  sfifo_prog #(
    .DATA_W(DATA_W), .DEPTH(DEPTH),
    .ALMOST_FULL_GAP(13'(AF)), .ALMOST_EMPTY_GAP(13'(AE)),
    .FWFT(FWFT), .OUT_REG(OUT_REG)
  ) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .din(din), .rd_en(rd_en),
    .dout(dout), .dout_valid(dout_valid), .full(full), .empty(empty),
    .almost_full(almost_full), .almost_empty(almost_empty),
    .overflow(overflow), .underflow(underflow)
  );

  logic [DATA_W-1:0] q[$];
  logic [DATA_W-1:0] p1d, p2d;
  bit                p1v, p2v, ovf_m, udf_m;
  int                stall;
  int unsigned       lfsr;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", NAME, tag, act, exp);
    end
  endtask

  task automatic check_all();
    int n = q.size();
    chk(full == (n == DEPTH), "R1 full", full, n == DEPTH);
    chk(empty == (n == 0), "R1 empty", empty, n == 0);
    chk(almost_full == ((DEPTH - n) <= AF), "R2 almost_full", almost_full, (DEPTH - n) <= AF);
    chk(almost_empty == (n <= AE), "R3 almost_empty", almost_empty, n <= AE);
    chk(overflow == ovf_m, "R8 overflow", overflow, ovf_m);
    chk(underflow == udf_m, "R8 underflow", underflow, udf_m);
    if (!FWFT) begin
      bit ev = OUT_REG ? p2v : p1v;
      logic [DATA_W-1:0] ed = OUT_REG ? p2d : p1d;
      chk(dout_valid == ev, OUT_REG ? "R5 valid timing" : "R4 valid timing", dout_valid, ev);
      if (ev) chk(dout == ed, "R7 data order", dout, ed);
    end else begin
      if (dout_valid) begin
        chk(n > 0, "R6 valid with words held", n, 1);
        if (n > 0) chk(dout == q[0], "R7 head word", dout, q[0]);
      end
      if (n > 0 && !dout_valid) stall++;
      else stall = 0;
      chk(stall <= 2, "R6 head presented in time", stall, 2);
    end
  endtask

  task automatic clear_model();
    q.delete();
    p1v = 0; p2v = 0; ovf_m = 0; udf_m = 0; stall = 0;
  endtask

  task automatic step(input bit w, input bit r, input logic [DATA_W-1:0] d);
    bit vb;
    bit wok, rok;
    logic [DATA_W-1:0] popped;
    wr_en = w; rd_en = r; din = d;
    vb = dout_valid;
    @(posedge clk);
    wok = w && (q.size() < DEPTH);
    rok = FWFT ? (r && vb) : (r && q.size() > 0);
    if (w && !wok) ovf_m = 1;
    if (r && !rok) udf_m = 1;
    popped = '0;
    if (rok) popped = q.pop_front();
    if (wok) q.push_back(d);
    if (!FWFT) begin
      p2v = p1v; p2d = p1d;
      p1v = rok; p1d = popped;
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic do_reset();
    rst = 1; wr_en = 0; rd_en = 0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    clear_model();
    // R10: reset state at the ports
    chk(empty == 1'b1, "R10 empty after reset", empty, 1);
    chk(full == 1'b0, "R10 full after reset", full, 0);
    chk(almost_empty == 1'b1, "R10 almost_empty after reset", almost_empty, 1);
    chk(almost_full == 1'b0, "R10 almost_full after reset", almost_full, 0);
    chk(dout_valid == 1'b0, "R10 valid after reset", dout_valid, 0);
    chk(!overflow && !underflow, "R10 errors after reset", overflow | underflow, 0);
    rst = 0;
  endtask

  function automatic logic [DATA_W-1:0] word(input int k);
    return DATA_W'(k * 7 + 3);
  endfunction

  initial begin
    done = 0; checks = 0; errors = 0;
    rst = 1; wr_en = 0; rd_en = 0; din = '0;
    clear_model();
    lfsr = 32'hACE1_2F37;
    @(negedge clk);
    do_reset();

    // R8: read with nothing to deliver
    step(0, 1, '0);
    chk(underflow == 1'b1, "R8 underflow sets", underflow, 1);
    step(0, 0, '0);
    chk(underflow == 1'b1, "R8 underflow sticky", underflow, 1);

    // first word into an empty buffer
    step(1, 0, word(1));
    if (FWFT) begin
      step(0, 0, '0);
      step(0, 0, '0);
      chk(dout_valid && dout == word(1), "R6 fall-through without strobe", dout, word(1));
      step(0, 0, '0);
      chk(dout_valid && dout == word(1), "R6 head holds", dout, word(1));
      step(0, 1, '0);
    end else begin
      step(0, 1, '0);
      if (!OUT_REG)
        chk(dout_valid && dout == word(1), "R4 one-cycle read", dout, word(1));
      else begin
        chk(!dout_valid, "R5 not yet valid", dout_valid, 0);
        step(0, 0, '0);
        chk(dout_valid && dout == word(1), "R5 two-cycle read", dout, word(1));
      end
    end
    step(0, 0, '0);
    step(0, 0, '0);

    // fill past full: R1 R2 R3 walk and R8 overflow
    for (int i = 0; i < DEPTH + 3; i++) step(1, 0, word(10 + i));
    chk(full && overflow, "R8 overflow on full", {full, overflow}, 3);
    // R8: contents unchanged by refused writes, checked while draining
    step(1, 1, word(99));
    for (int i = 0; i < DEPTH + 6; i++) step(0, 1, '0);
    chk(empty == 1'b1, "R1 drained", empty, 1);

    // R10 mid-run reset with words held
    for (int i = 0; i < 5; i++) step(1, 0, word(40 + i));
    do_reset();

    // R9: three words held, simultaneous write and served read
    for (int i = 0; i < AE + 1; i++) step(1, 0, word(60 + i));
    step(0, 0, '0);
    step(0, 0, '0);
    step(1, 1, word(70));
    chk(!almost_empty && !empty, "R9 count unchanged", almost_empty, 0);
    step(0, 0, '0);
    chk(!almost_empty && !empty, "R9 count still unchanged", almost_empty, 0);

    // mixed traffic in three phases
    for (int ph = 0; ph < 3; ph++) begin
      for (int i = 0; i < 300; i++) begin
        int wth = (ph == 0) ? 12 : (ph == 1) ? 8 : 4;
        int rth = (ph == 0) ? 4 : (ph == 1) ? 8 : 12;
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        step((lfsr[3:0] < 4'(wth)), (lfsr[7:4] < 4'(rth)), DATA_W'(lfsr >> 8));
      end
    end
    for (int i = 0; i < DEPTH + 6; i++) step(0, 1, '0);
    chk(empty == 1'b1, "R7 all words delivered", empty, 1);
    done = 1;
  end
endmodule

module sfifo_prog_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic d0, d1, d2;
  int   c0, c1, c2, e0, e1, e2;

  sfifo_prog_tb_cfg #(.NAME("req_noreg"), .DATA_W(9),  .FWFT(1'b0), .OUT_REG(1'b0))
    h_req (.clk(clk), .done(d0), .checks(c0), .errors(e0));
  sfifo_prog_tb_cfg #(.NAME("req_reg"),   .DATA_W(4),  .FWFT(1'b0), .OUT_REG(1'b1))
    h_reg (.clk(clk), .done(d1), .checks(c1), .errors(e1));
  sfifo_prog_tb_cfg #(.NAME("fwft_reg"),  .DATA_W(18), .FWFT(1'b1), .OUT_REG(1'b1))
    h_fwft (.clk(clk), .done(d2), .checks(c2), .errors(e2));

  initial begin
    int extra;
    extra = 0;
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (d0 && d1 && d2) break;
    end
    if (!(d0 && d1 && d2)) begin
      extra = 1;
      $display("FAIL watchdog run did not finish actual 0 expected 1");
    end
    $display("  CHECKS %0d ERRORS %0d", c0 + c1 + c2 + extra, e0 + e1 + e2 + extra);
    $finish;
  end
endmodule